// File: doc/BRIEF.md
# Serial EEPROM Power-On Configuration Loader

This block runs once after every reset and fills the adapter's identity storage and configuration registers from a three-wire serial EEPROM. While reset is held, it samples a set of strap inputs. The three configuration bytes and a three-bit board revision field take their default values from these straps. Two further straps are sampled at the same time. The width strap chooses 16-bit or 8-bit host mode. The load strap decides whether the EEPROM is read at all.

When loading is enabled, the block reads ten 16-bit words, one framed read each, with chip select dropped between reads:
- Words 0 to 6 fill storage entries 0 to 6.
- Entry 7 is filled from word 7 in 16-bit mode, or from word 8 in 8-bit mode.
- Word 0x0E then replaces configuration bytes A and B.
- Word 0x0F replaces byte C and supplies a protection byte. That byte clears the in-situ programming permission when it holds the lock value.

A sticky done flag marks the end of the sequence.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is low, cfg_a, cfg_b, cfg_c and sig_hi follow the strap inputs, and ee_cs, ee_sk, insitu_en and all storage words are 0. done equals 1 when strap_load is low and 0 otherwise.
- R2: Each word read keeps ee_cs high for 26 serial clock rises. On rises 1 to 9, ee_di carries 1, 1, 0 and then the 6-bit word address, MSB first. Rise 10 is a dummy bit. ee_do is captured on rises 11 to 26, MSB first.
- R3: Words 0 to 6 are read in ascending order and land in storage entries 0 to 6. Entry i occupies store_words[16*i+15:16*i].
- R4: With strap_wide high at reset, the eighth read is word 7, and it lands in entry 7.
- R5: With strap_wide low at reset, word 7 is never addressed. The eighth read is word 8, and it lands in entry 7.
- R6: With strap_load high, words 0x0E and 0x0F are read last, in that order. cfg_a takes bits 7:0 of word 0x0E, cfg_b takes its bits 15:8, and cfg_c takes bits 7:0 of word 0x0F. sig_hi keeps its strap value.
- R7: With strap_load low at reset, ee_cs never rises. done is high on the first cycle after reset. Configuration bytes keep their strap values, storage stays 0 and insitu_en stays 0.
- R8: After loading, insitu_en is 0 when bits 15:8 of word 0x0F equal 0x73, and 1 for any other value.
- R9: ee_sk is low whenever ee_cs is low. Between two reads, ee_cs stays low for at least 2*CLK_DIV clock cycles.
- R10: Once done is high, it stays high until the next reset. From then on, the storage and configuration outputs stay constant.
- R11: Within a read, consecutive ee_sk rises are exactly 2*CLK_DIV clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_wide | input | 1 | 1 selects 16-bit host mode, 0 selects 8-bit |
| strap_load | input | 1 | 1 enables the EEPROM load sequence |
| strap_cfg_a | input | 8 | Default for configuration byte A |
| strap_cfg_b | input | 8 | Default for configuration byte B |
| strap_cfg_c | input | 8 | Default for configuration byte C |
| strap_sig | input | 3 | Board revision bits |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |
| store_words | output | 128 | Eight 16-bit storage entries, entry 0 in the low bits |
| cfg_a | output | 8 | Configuration byte A |
| cfg_b | output | 8 | Configuration byte B |
| cfg_c | output | 8 | Configuration byte C |
| sig_hi | output | 3 | Upper signature bits, strap-derived |
| insitu_en | output | 1 | In-situ programming permitted |
| done | output | 1 | Load sequence finished |

## Verification
A read costs 2 chip-select-low ticks plus 52 serial half-periods of CLK_DIV cycles each, so with the default divider a word takes 216 cycles. Ten words finish roughly 2160 cycles after reset. A word's address is fixed by the ninth ee_sk rise. Its value reaches the outputs on the clock tick that ends the frame, which is the falling edge after rise 26. done rises on that same tick for the last word.

The EEPROM model checks the frame and pops the expected address from the scoreboard at the ninth rise. It also times rise spacing and chip-select gaps on the serial edges themselves. Register outputs are compared at a falling clock edge only after done is seen high, and once more 64 cycles later. With loading disabled, done is required on the very first cycle after reset.

// File: rtl/eeprom_cfg_loader.sv
`timescale 1ns/1ps
module eeprom_cfg_loader #(
  parameter int          CLK_DIV   = 4,
  parameter int          ADDR_W    = 6,
  parameter logic [7:0]  LOCK_BYTE = 8'h73
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap_wide,
  input  logic         strap_load,
  input  logic [7:0]   strap_cfg_a,
  input  logic [7:0]   strap_cfg_b,
  input  logic [7:0]   strap_cfg_c,
  input  logic [2:0]   strap_sig,
  output logic         ee_cs,
  output logic         ee_sk,
  output logic         ee_di,
  input  logic         ee_do,
  output logic [127:0] store_words,
  output logic [7:0]   cfg_a,
  output logic [7:0]   cfg_b,
  output logic [7:0]   cfg_c,
  output logic [2:0]   sig_hi,
  output logic         insitu_en,
  output logic         done
);
  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int FRAME    = CMD_BITS + 1 + 16;
  localparam int FW       = $clog2(FRAME + 1);
  localparam int DW       = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int LAST_W   = 9;

  typedef enum logic [1:0] {S_GAP, S_XFER, S_DONE} st_t;

  st_t               st;
  logic [DW-1:0]     div_cnt;
  logic              tick;
  logic              gap_half;
  logic [FW-1:0]     slot;
  logic [3:0]        widx;
  logic [15:0]       shreg;
  logic              wide_q;
  logic              load_q;
  logic [ADDR_W-1:0] addr;
  logic [CMD_BITS-1:0] cmd;

  assign tick = (div_cnt == DW'(CLK_DIV - 1));
  assign done = (st == S_DONE);

  always_comb begin
    if (widx < 4'd7)       addr = ADDR_W'(widx);
    else if (widx == 4'd7) addr = wide_q ? ADDR_W'(7) : ADDR_W'(8);
    else if (widx == 4'd8) addr = ADDR_W'(14);
    else                   addr = ADDR_W'(15);
  end

  assign cmd   = {3'b110, addr};
  assign ee_di = (st == S_XFER) && (slot < FW'(CMD_BITS)) ? cmd[FW'(CMD_BITS - 1) - slot] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= strap_load ? S_GAP : S_DONE;
      div_cnt     <= '0;
      ee_cs       <= 1'b0;
      ee_sk       <= 1'b0;
      gap_half    <= 1'b0;
      slot        <= '0;
      widx        <= '0;
      shreg       <= '0;
      wide_q      <= strap_wide;
      load_q      <= strap_load;
      store_words <= '0;
      cfg_a       <= strap_cfg_a;
      cfg_b       <= strap_cfg_b;
      cfg_c       <= strap_cfg_c;
      sig_hi      <= strap_sig;
      insitu_en   <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        case (st)
          S_GAP: begin
            if (gap_half) begin
              gap_half <= 1'b0;
              ee_cs    <= 1'b1;
              slot     <= '0;
              st       <= S_XFER;
            end else begin
              gap_half <= 1'b1;
            end
          end
          S_XFER: begin
            if (!ee_sk) begin
              ee_sk <= 1'b1;
              if (slot > FW'(CMD_BITS)) shreg <= {shreg[14:0], ee_do};
            end else begin
              ee_sk <= 1'b0;
              if (slot == FW'(FRAME - 1)) begin
                ee_cs <= 1'b0;
                if (widx < 4'd8) store_words[widx[2:0]*16 +: 16] <= shreg;
                else if (widx == 4'd8) begin
                  cfg_a <= shreg[7:0];
                  cfg_b <= shreg[15:8];
                end else begin
                  cfg_c     <= shreg[7:0];
                  insitu_en <= (shreg[15:8] != LOCK_BYTE);
                end
                widx <= widx + 1'b1;
                st   <= (widx == 4'(LAST_W)) ? S_DONE : S_GAP;
              end else begin
                slot <= slot + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [15:0] low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (ee_cs)                      low_cnt <= '0;
    else if (low_cnt != 16'hFFFF)        low_cnt <= low_cnt + 1'b1;
  end

  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (low_cnt >= 16'(2 * CLK_DIV)));

  assert_sk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);

  assert_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |-> (!ee_cs && done));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(store_words) && $stable(cfg_a) && $stable(cfg_b)
              && $stable(cfg_c) && $stable(insitu_en)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ee_cs);
endmodule

// File: tb/eeprom_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module eeprom_cfg_loader_tb_top;
  localparam int DIV = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic strap_wide = 0, strap_load = 0;
  logic [7:0] strap_cfg_a = 0, strap_cfg_b = 0, strap_cfg_c = 0;
  logic [2:0] strap_sig = 0;
  logic ee_cs, ee_sk, ee_di;
  logic ee_do_r = 0;
  logic [127:0] store_words;
  logic [7:0] cfg_a, cfg_b, cfg_c;
  logic [2:0] sig_hi;
  logic insitu_en, done;

  int compared = 0, mismatched = 0;
  int cyc = 0;
  logic [15:0] w_e, w_f;
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eeprom_cfg_loader #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_wide(strap_wide), .strap_load(strap_load),
    .strap_cfg_a(strap_cfg_a), .strap_cfg_b(strap_cfg_b), .strap_cfg_c(strap_cfg_c),
    .strap_sig(strap_sig), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do_r),
    .store_words(store_words), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
    .sig_hi(sig_hi), .insitu_en(insitu_en), .done(done));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_val(input int a);
    if (a == 14) return w_e;
    if (a == 15) return w_f;
    return 16'hC3A0 ^ 16'(a * 16'h0111);
  endfunction

  int bitn = 0, t_rise = 0, t_cs_low = 0, cs_rises = 0;
  bit gap_valid = 0;
  logic [8:0] cmd;
  logic [15:0] rdat;

  always @(posedge ee_cs) begin
    cs_rises++;
    if (gap_valid) chk("R9 cs gap", 32'(cyc - t_cs_low >= 2*DIV), 1);
    bitn = 0; cmd = 0;
  end
  always @(negedge ee_cs) begin t_cs_low = cyc; gap_valid = 1; end

  always @(posedge ee_sk) if (ee_cs) begin
    if (bitn < 9) cmd = {cmd[7:0], ee_di};
    bitn++;
    if (bitn == 2) chk("R11 sk period", 32'(cyc - t_rise), 2*DIV);
    t_rise = cyc;
    if (bitn == 9) begin
      chk("R2 start/opcode", 32'(cmd[8:6]), 32'b110);
      if (exp_q.size() == 0) chk("R3 unexpected read", 32'(cmd[5:0]), 32'hFF);
      else chk("R3/R4/R5/R6 read address", 32'(cmd[5:0]), 32'(exp_q.pop_front()));
      rdat = mem_val(int'(cmd[5:0]));
    end
    if (bitn == 26) chk("R2 frame length", 32'(ee_cs), 1);
  end

  always @(negedge ee_sk) if (ee_cs && bitn >= 9) begin
    if (bitn == 9) ee_do_r = 1'b0;
    else begin ee_do_r = rdat[15]; rdat = {rdat[14:0], 1'b0}; end
  end

  task automatic push_seq(input logic wide);
    for (int i = 0; i < 7; i++) exp_q.push_back(i);
    exp_q.push_back(wide ? 7 : 8);
    exp_q.push_back(14);
    exp_q.push_back(15);
  endtask

  task automatic run_case(input logic wide, input logic load, input logic [15:0] we,
                          input logic [15:0] wf, input logic [7:0] sa, input logic [2:0] ss);
    int n;
    logic [7:0] ea, eb, ec;
    @(negedge clk);
    rst_n = 0;
    strap_wide = wide; strap_load = load;
    strap_cfg_a = sa; strap_cfg_b = sa ^ 8'hFF; strap_cfg_c = sa + 8'h11; strap_sig = ss;
    w_e = we; w_f = wf;
    exp_q.delete();
    repeat (4) @(negedge clk);
    chk("R1 cfg_a", 32'(cfg_a), 32'(sa));
    chk("R1 cfg_b", 32'(cfg_b), 32'(sa ^ 8'hFF));
    chk("R1 cfg_c", 32'(cfg_c), 32'(8'(sa + 8'h11)));
    chk("R1 sig_hi", 32'(sig_hi), 32'(ss));
    chk("R1 done", 32'(done), 32'(!load));
    chk("R1 idle pins/flag", 32'({ee_cs, ee_sk, insitu_en}), 0);
    chk("R1 store", 32'(store_words != 0), 0);
    if (load) push_seq(wide);
    cs_rises = 0; gap_valid = 0;
    rst_n = 1;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk("R10 done reached", 32'(done), 1);
    if (!load) begin
      chk("R7 done at once", 32'(n), 0);
      repeat (200) @(negedge clk);
      chk("R7 no chip select", 32'(cs_rises), 0);
      chk("R7 store zero", 32'(store_words != 0), 0);
      ea = sa; eb = sa ^ 8'hFF; ec = sa + 8'h11;
      chk("R7 insitu", 32'(insitu_en), 0);
    end else begin
      chk("R4/R5/R6 all reads made", 32'(exp_q.size()), 0);
      chk("R2 ten frames", 32'(cs_rises), 10);
      for (int i = 0; i < 7; i++)
        chk("R3 entry", 32'(store_words[i*16 +: 16]), 32'(mem_val(i)));
      chk(wide ? "R4 entry 7" : "R5 entry 7", 32'(store_words[112 +: 16]),
          32'(mem_val(wide ? 7 : 8)));
      ea = we[7:0]; eb = we[15:8]; ec = wf[7:0];
      chk("R8 insitu", 32'(insitu_en), 32'(wf[15:8] != 8'h73));
    end
    chk("R6 cfg_a", 32'(cfg_a), 32'(ea));
    chk("R6 cfg_b", 32'(cfg_b), 32'(eb));
    chk("R6 cfg_c", 32'(cfg_c), 32'(ec));
    chk("R6 sig_hi", 32'(sig_hi), 32'(ss));
    repeat (64) @(negedge clk);
    chk("R10 done sticky", 32'(done), 1);
    chk("R10 cfg stable", 32'({cfg_a, cfg_b, cfg_c}), 32'({ea, eb, ec}));
  endtask

  initial begin
    run_case(1'b1, 1'b1, 16'h8C41, 16'h1234, 8'h15, 3'b101);
    run_case(1'b0, 1'b1, 16'h0753, 16'h7361, 8'h3C, 3'b010);
    run_case(1'b1, 1'b0, 16'hAAAA, 16'h7300, 8'h47, 3'b111);
    run_case(1'b1, 1'b1, 16'hFE01, 16'h72C5, 8'h00, 3'b000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule